// File: doc/BRIEF.md
# Transparent Write Blitter (8-bit pixels, host-fed)

The block copies a rectangle of 8-bit pixels, supplied by a host as a stream of 16-bit words, into a byte-addressed frame buffer. On `start` it latches the destination start address, the line pitch (stride), the rectangle size (width and height, each stored as count minus one), an alignment flag (bit 0 of a source start address) and a key color. It then takes host words one at a time and splits each into one or two pixels. For each pixel it either issues a one-byte memory write or, if the pixel equals the key color, skips the write while still stepping the address.

Each row begins in a fresh host word. When the alignment flag is 0, the first pixel of a row is the low byte of its first word. When the flag is 1, the first pixel is the high byte and the low byte of that word is thrown away. If a row ends partway through a word, the single remaining pixel is the low byte of that word and the high byte is dropped. So a row uses floor((W + 1 + phase) / 2) words and the job uses that many times H. A host may also present a 32-bit write, which is taken as two word writes: low half first, then high half.

The controller is a five-state machine. IDLE waits for `start`. FETCH raises `host_ready` and waits for a host write. LO_SLOT handles the low byte of the held word and HI_SLOT handles the high byte. FINISH issues the one-cycle `done` pulse and returns to IDLE. The transitions are:
- IDLE to FETCH on start.
- FETCH to LO_SLOT, or to HI_SLOT when the row is at its first pixel and phase is 1.
- LO_SLOT to HI_SLOT when the row continues.
- LO_SLOT or HI_SLOT back to FETCH when the word is used up.
- LO_SLOT or HI_SLOT to the slot chosen for the held upper half when a 32-bit write still has a word pending.
- LO_SLOT or HI_SLOT to FINISH on the last pixel of the rectangle.

Top module: `xparent_blitter`

## Requirements
- R1: While idle, `busy`, `host_ready`, `done` and `mem_we` are 0, and host writes made while idle produce no memory write and are not counted toward the next job.
- R2: `start` in IDLE latches all configuration inputs; `start` or configuration changes while busy have no effect on the running job.
- R3: With phase 0, the pixels of a row are taken from its words in the order low byte, then high byte, word after word.
- R4: With phase 1, the first word of every row contributes only its high byte; its low byte is discarded.
- R5: When a row ends inside a word, the last pixel is that word's low byte; the high byte is discarded and the next row starts in a new word.
- R6: A job takes exactly floor((W+1+phase)/2)×H host words. `busy` stays 1 until that count is reached. After the last pixel, `done` is 1 for exactly one cycle while `busy` returns to 0.
- R7: A pixel equal to the latched key color causes no memory write. All other pixels are written, `mem_data` carrying the pixel value.
- R8: The pixel at column c of row r is written to address dst + r×stride + c. Skipped pixels still advance the column.
- R9: A host write with `host_wide`=1 carries two words in `host_data` (bits 15:0 first, then bits 31:16) and counts as two words.
- R10: `host_ready` is 1 only while waiting for a host word during a job. A write is accepted on a clock edge where `host_wr` and `host_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (honoured only when idle) |
| dst_addr | input | AW | Destination start byte address |
| stride | input | AW | Bytes from one row start to the next |
| width_m1 | input | DW | Rectangle width in pixels minus one |
| height_m1 | input | DW | Rectangle height in rows minus one |
| src_addr | input | AW | Source start address; bit 0 is the phase |
| key_color | input | 8 | Pixel value that is not written |
| host_wr | input | 1 | Host write strobe |
| host_wide | input | 1 | Write carries two words |
| host_data | input | 32 | Host data (upper half used only when wide) |
| host_ready | output | 1 | Block waits for a host word |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_we | output | 1 | Byte write enable to frame buffer |
| mem_addr | output | AW | Byte write address |
| mem_data | output | 8 | Byte write data |

## Verification
Directed jobs cover each phase with even and odd widths, and single-pixel-wide columns in both phases. Together these separate a correct byte choice at row start (R4) and at row end (R5) from an off-by-one in either place. Rows filled heavily with the key color show whether skipping also stalls the address (R7, R8). Jobs fed entirely by 32-bit writes show the half ordering (R9) and that a held upper half may start a new row. Seeded random jobs mix all of these with random stride, key and wide/narrow writes. A start pulse with altered configuration in mid-job and writes made while idle cover R1 and R2.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LO,
        ST_HI,
        ST_FINISH
    } blit_state_e;
endpackage

// File: rtl/blit_walk.sv
// Column/row counters and destination address stepping.
module blit_walk #(
    parameter int AW = 20,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [DW-1:0] wm1,
    input  logic [DW-1:0] hm1,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          col_zero,
    output logic          row_last,
    output logic          last_pix
);
    logic [DW-1:0] col_q, row_q, wm1_q, hm1_q;
    logic [AW-1:0] row_base_q, addr_q, stride_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q      <= '0;
            row_q      <= '0;
            wm1_q      <= '0;
            hm1_q      <= '0;
            row_base_q <= '0;
            addr_q     <= '0;
            stride_q   <= '0;
        end else if (init) begin
            col_q      <= '0;
            row_q      <= '0;
            wm1_q      <= wm1;
            hm1_q      <= hm1;
            row_base_q <= base;
            addr_q     <= base;
            stride_q   <= stride;
        end else if (step) begin
            if (col_q == wm1_q) begin
                col_q      <= '0;
                row_q      <= row_q + 1'b1;
                row_base_q <= row_base_q + stride_q;
                addr_q     <= row_base_q + stride_q;
            end else begin
                col_q  <= col_q + 1'b1;
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign addr     = addr_q;
    assign col_zero = (col_q == '0);
    assign row_last = (col_q == wm1_q);
    assign last_pix = row_last && (row_q == hm1_q);
endmodule

// File: rtl/blit_word.sv
// Holds the current host word (or word pair), selects a byte, compares to key.
module blit_word (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic [7:0]  key,
    input  logic        load,
    input  logic [31:0] load_data,
    input  logic        load_wide,
    input  logic        shift,
    input  logic        sel_hi,
    output logic [7:0]  pix,
    output logic        is_key,
    output logic        more,
    output logic [7:0]  key_q
);
    logic [31:0] data_q;
    logic        more_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            more_q <= 1'b0;
            key_q  <= '0;
        end else begin
            if (init) key_q <= key;
            if (load) begin
                data_q <= load_data;
                more_q <= load_wide;
            end else if (shift) begin
                data_q <= {16'h0000, data_q[31:16]};
                more_q <= 1'b0;
            end
        end
    end

    assign pix    = sel_hi ? data_q[15:8] : data_q[7:0];
    assign is_key = (pix == key_q);
    assign more   = more_q;
endmodule

// File: rtl/blit_ctrl.sv
// Job sequencer: one process for the state register, one for next state, one for outputs.
module blit_ctrl
    import blit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic phase_in,
    input  logic host_wr,
    input  logic more,
    input  logic col_zero,
    input  logic row_last,
    input  logic last_pix,
    input  logic is_key,
    output logic init,
    output logic load,
    output logic shift,
    output logic step,
    output logic sel_hi,
    output logic pix_we,
    output logic host_ready,
    output logic busy,
    output logic done
);
    blit_state_e state_q, state_d;
    logic        phase_q;
    blit_state_e row_entry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (init) phase_q <= phase_in;
        end
    end

    // slot used for the first pixel of a row
    assign row_entry = phase_q ? ST_HI : ST_LO;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  if (host_wr) state_d = (col_zero && phase_q) ? ST_HI : ST_LO;
            ST_LO: begin
                if (last_pix)      state_d = ST_FINISH;
                else if (row_last) state_d = more ? row_entry : ST_FETCH;
                else               state_d = ST_HI;
            end
            ST_HI: begin
                if (last_pix)  state_d = ST_FINISH;
                else if (more) state_d = row_last ? row_entry : ST_LO;
                else           state_d = ST_FETCH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        init       = 1'b0;
        load       = 1'b0;
        shift      = 1'b0;
        step       = 1'b0;
        sel_hi     = 1'b0;
        host_ready = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  init = start;
            ST_FETCH: begin
                host_ready = 1'b1;
                busy       = 1'b1;
                load       = host_wr;
            end
            ST_LO: begin
                busy  = 1'b1;
                step  = 1'b1;
                shift = !last_pix && row_last && more;
            end
            ST_HI: begin
                busy   = 1'b1;
                step   = 1'b1;
                sel_hi = 1'b1;
                shift  = !last_pix && more;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
        pix_we = step && !is_key;
    end
endmodule

// File: rtl/xparent_blitter.sv
module xparent_blitter #(
    parameter int AW = 20,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] stride,
    input  logic [DW-1:0] width_m1,
    input  logic [DW-1:0] height_m1,
    input  logic [AW-1:0] src_addr,
    input  logic [7:0]    key_color,
    input  logic          host_wr,
    input  logic          host_wide,
    input  logic [31:0]   host_data,
    output logic          host_ready,
    output logic          busy,
    output logic          done,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data
);
    logic init, load, shift, step, sel_hi, pix_we;
    logic more, col_zero, row_last, last_pix, is_key;
    logic [7:0] pix, key_lat;
    logic unused_src;

    assign unused_src = ^src_addr[AW-1:1];

    blit_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_in(src_addr[0]),
        .host_wr(host_wr), .more(more), .col_zero(col_zero),
        .row_last(row_last), .last_pix(last_pix), .is_key(is_key),
        .init(init), .load(load), .shift(shift), .step(step),
        .sel_hi(sel_hi), .pix_we(pix_we), .host_ready(host_ready),
        .busy(busy), .done(done)
    );

    blit_walk #(.AW(AW), .DW(DW)) i_walk (
        .clk(clk), .rst_n(rst_n), .init(init), .base(dst_addr),
        .stride(stride), .wm1(width_m1), .hm1(height_m1), .step(step),
        .addr(mem_addr), .col_zero(col_zero), .row_last(row_last),
        .last_pix(last_pix)
    );

    blit_word i_word (
        .clk(clk), .rst_n(rst_n), .init(init), .key(key_color),
        .load(load), .load_data(host_data), .load_wide(host_wide),
        .shift(shift), .sel_hi(sel_hi), .pix(pix), .is_key(is_key),
        .more(more), .key_q(key_lat)
    );

    assign mem_we   = pix_we;
    assign mem_data = pix;
endmodule

// File: rtl/blit_checker.sv
module blit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ready,
    input logic       busy,
    input logic       done,
    input logic       mem_we,
    input logic [7:0] mem_data,
    input logic [7:0] key
);
    a_r10_ready_in_job: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> busy);
    a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
    a_r7_no_key_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_data != key));
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_busy_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind xparent_blitter blit_checker i_chk (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .busy(busy),
    .done(done), .mem_we(mem_we), .mem_data(mem_data), .key(key_lat)
);

// File: tb/test_xparent_blitter.sv
`timescale 1ns/1ps
module test_xparent_blitter;
    localparam int AW = 20;
    localparam int DW = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] dst_addr = '0, stride = '0, src_addr = '0;
    logic [DW-1:0] width_m1 = '0, height_m1 = '0;
    logic [7:0] key_color = '0;
    logic host_wr = 1'b0, host_wide = 1'b0;
    logic [31:0] host_data = '0;
    logic host_ready, busy, done, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_data;

    int checks = 0, errors = 0, cycles = 0;
    logic [15:0] words [0:255];
    int exp_addr [0:511];
    int exp_data [0:511];
    int act_addr [0:511];
    int act_data [0:511];
    int exp_n = 0, act_n = 0, done_cnt = 0;

    xparent_blitter #(.AW(AW), .DW(DW)) i_xparent_blitter (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .stride(stride), .width_m1(width_m1), .height_m1(height_m1),
        .src_addr(src_addr), .key_color(key_color), .host_wr(host_wr),
        .host_wide(host_wide), .host_data(host_data), .host_ready(host_ready),
        .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (mem_we && act_n < 512) begin
            act_addr[act_n] = int'(mem_addr);
            act_data[act_n] = int'(mem_data);
            act_n++;
        end
        if (done) done_cnt++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // expected writes from the word list: row stream byte k, pixels k = p .. p+W-1
    function automatic void build_expect(int w, int h, int p, int dst, int strd, int key);
        int wpr;
        wpr = (w + 1 + p) / 2;
        exp_n = 0;
        for (int r = 0; r < h; r++) begin
            for (int k = p; k < p + w; k++) begin
                logic [15:0] wd;
                int px;
                wd = words[r * wpr + k / 2];
                px = (k % 2 == 1) ? int'(wd[15:8]) : int'(wd[7:0]);
                if (px != key) begin
                    exp_addr[exp_n] = (dst + r * strd + (k - p)) % (1 << AW);
                    exp_data[exp_n] = px;
                    exp_n++;
                end
            end
        end
    endfunction

    task automatic send(input logic [31:0] d, input logic wide);
        while (!host_ready) @(negedge clk);
        host_wr = 1'b1;
        host_wide = wide;
        host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
        host_wide = 1'b0;
        host_data = $urandom;
    endtask

    // widemode: 0 narrow only, 1 all wide where possible, 2 random mix
    task automatic run_job(input int w, input int h, input int p, input int keybias,
                           input int widemode, input bit disturb, input string tag);
        int n, d0, s0, base_done, i;
        logic [7:0] key;
        bit wd;
        key = 8'($urandom);
        d0 = int'($urandom % 4096);
        s0 = w + int'($urandom % 20);
        n = ((w + 1 + p) / 2) * h;
        for (int j = 0; j < n; j++) begin
            logic [7:0] b0, b1;
            b0 = (int'($urandom % 4) < keybias) ? key : 8'($urandom);
            b1 = (int'($urandom % 4) < keybias) ? key : 8'($urandom);
            words[j] = {b1, b0};
        end
        build_expect(w, h, p, d0, s0, int'(key));
        dst_addr = AW'(d0);
        stride = AW'(s0);
        width_m1 = DW'(w - 1);
        height_m1 = DW'(h - 1);
        src_addr = {AW'($urandom % 512), 1'b0} | AW'(p);
        key_color = key;
        act_n = 0;
        base_done = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(host_ready == 1'b1, {tag, " R10 ready after start"}, int'(host_ready), 1);
        i = 0;
        while (i < n) begin
            wd = (widemode == 1) || (widemode == 2 && ($urandom % 2 == 1));
            if (wd && i + 1 < n) begin
                if (i + 2 == n)
                    check(busy && done_cnt == base_done, {tag, " R6 busy before last word"}, int'(busy), 1);
                send({words[i + 1], words[i]}, 1'b1);
                i += 2;
            end else begin
                if (i + 1 == n)
                    check(busy && done_cnt == base_done, {tag, " R6 busy before last word"}, int'(busy), 1);
                send({16'hA5C3, words[i]}, 1'b0);
                i += 1;
            end
            if (disturb && i == 1) begin
                dst_addr = dst_addr + 7;
                key_color = ~key;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        for (int t = 0; t < 40 && done_cnt == base_done; t++) @(negedge clk);
        @(negedge clk);
        check(done_cnt - base_done == 1, {tag, " R6 one done pulse"}, done_cnt - base_done, 1);
        check(busy == 1'b0 && host_ready == 1'b0, {tag, " R6 idle after job"}, int'(busy), 0);
        check(act_n == exp_n, {tag, " R7 write count"}, act_n, exp_n);
        for (int k = 0; k < exp_n && k < act_n; k++) begin
            check(act_addr[k] == exp_addr[k], {tag, " R8 write address"}, act_addr[k], exp_addr[k]);
            check(act_data[k] == exp_data[k], {tag, " R3/R4/R5 write data"}, act_data[k], exp_data[k]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'(busy), 0);
        check(host_ready == 1'b0 && mem_we == 1'b0, "R1 reset ready/we", int'(host_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: host writes while idle are ignored
        for (int t = 0; t < 5; t++) begin
            host_wr = 1'b1;
            host_data = $urandom;
            @(negedge clk);
        end
        host_wr = 1'b0;
        check(act_n == 0 && busy == 1'b0, "R1 idle writes ignored", act_n, 0);
        run_job(4, 2, 0, 0, 0, 1'b0, "R1 job after idle writes");
        run_job(6, 3, 0, 0, 0, 1'b0, "R3 phase0 even");
        run_job(5, 3, 1, 0, 0, 1'b0, "R4 phase1 odd");
        run_job(4, 2, 1, 0, 0, 1'b0, "R4 phase1 even");
        run_job(3, 2, 0, 0, 0, 1'b0, "R5 odd end low byte");
        run_job(1, 3, 0, 0, 0, 1'b0, "R5 width1 phase0");
        run_job(1, 3, 1, 0, 0, 1'b0, "R4 width1 phase1");
        run_job(8, 2, 0, 3, 0, 1'b0, "R7 key heavy");
        run_job(6, 3, 1, 1, 1, 1'b0, "R9 all wide");
        run_job(3, 4, 0, 0, 1, 1'b0, "R9 wide across rows");
        run_job(5, 2, 0, 1, 0, 1'b1, "R2 start while busy");
        for (int j = 0; j < 40; j++)
            run_job(1 + int'($urandom % 16), 1 + int'($urandom % 6), int'($urandom % 2),
                    int'($urandom % 3), 2, 1'b0, "R8 random");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule